// File: doc/BRIEF.md
# Switching Output Stage Fault Supervisor

This block decides, cycle by cycle, whether the power transistors of a switching audio output stage are allowed to switch. It watches three digital flags from on-die temperature comparators (a warning threshold, a shutdown threshold and a lower recovery threshold), one overcurrent flag per power transistor, the PWM control inputs, an active-low mute request and a slow timebase tick. From these it drives a single output-enable and four active-low fault indications: thermal warning, thermal shutdown, overcurrent and data loss.

Thermal faults clear themselves, with hysteresis: once raised they stay up until the recovery comparator reports the die has cooled. An overcurrent fault is sticky and is removed only by a reset or by a mute request that is asserted and then released. In bridged (two-channel) mode the two PWM inputs that drive the bridges are watched for activity. A bridge input that stops toggling would put a DC voltage across the load, so a timeout counter clocked by the tick flags that case. In single-ended (four-channel) mode no activity check runs.

All asynchronous inputs pass through a two-stage synchronizer. Reset is applied asynchronously and released synchronously.

Top module: `cdf_supervisor`

## Requirements
- R1: A high `tmp_warn_i` drives `warn_n_o` low. The warning alone leaves `out_en_o` high.
- R2: A high `tmp_shut_i` drives `shut_n_o` and `warn_n_o` low and forces `out_en_o` low for as long as the shutdown state lasts.
- R3: Once raised, the thermal indications stay low while `tmp_cool_i` is low, even after the warning and shutdown flags drop. Both indications return high, and the shutdown gate on `out_en_o` lifts, only when `tmp_cool_i` is high and neither the warning nor the shutdown flag is high.
- R4: Any high bit of `oc_i` (bit k is transistor k, 0 to 7) drives `oc_n_o` low and `out_en_o` low. The fault stays latched after the flag drops.
- R5: The latched overcurrent fault clears only on reset, or when `mute_n_i` goes low and then high again while no `oc_i` bit is high. A mute release while an `oc_i` bit is still high does not clear it.
- R6: With `bridge_mode_i`=1, PWM channels 0 and 2 are monitored. `dloss_n_o` goes low once DLOSS_TICKS `tick_i` pulses have passed with no edge on a monitored channel. Any edge on that channel restarts its count. Channels 1 and 3 have no effect on `dloss_n_o`.
- R7: With `bridge_mode_i`=0, `dloss_n_o` stays high however many ticks pass without PWM edges.
- R8: `out_en_o` is high only when the synchronized mute input is released, no thermal shutdown is active and no overcurrent fault is latched. A low `mute_n_i` forces it low.
- R9: While `rst_n` is low, `out_en_o` is low, all four indications are high and all fault state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bridge_mode_i | input | 1 | 1 = bridged two-channel, 0 = four single-ended channels |
| tick_i | input | 1 | One-cycle timebase pulse for the activity timeout |
| pwm_i | input | 4 | PWM control inputs, channels 0..3 |
| mute_n_i | input | 1 | Active-low mute request |
| tmp_warn_i | input | 1 | Die above warning threshold |
| tmp_shut_i | input | 1 | Die above shutdown threshold |
| tmp_cool_i | input | 1 | Die below recovery threshold |
| oc_i | input | 8 | Per-transistor overcurrent flags |
| out_en_o | output | 1 | Outputs may switch |
| warn_n_o | output | 1 | Active-low thermal warning |
| shut_n_o | output | 1 | Active-low thermal shutdown |
| oc_n_o | output | 1 | Active-low latched overcurrent |
| dloss_n_o | output | 1 | Active-low PWM data loss |

## Verification
The assertions check on every cycle that a shutdown state, a latched overcurrent or an active mute all gate the output-enable on the next cycle. They also check that an overcurrent flag always sets the latch, that the latch falls only after a mute release, that the shutdown state holds until the recovery flag appears, and that a disabled activity monitor never reports a timeout. The bench scenarios show the full hysteresis walks through the warning and shutdown states. They sweep each of the eight transistor flags through set, hold and clear, including a mute release made while the flag is still high. They count ticks exactly to the activity-timeout boundary on both monitored channels, and check that the unmonitored channels and four-channel mode have no effect.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  typedef enum logic [1:0] {
    TH_NORM = 2'd0,
    TH_WARN = 2'd1,
    TH_SHUT = 2'd2
  } therm_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/cdf_sync.sv
module cdf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else if (s == 0) begin
          stg_q[s] <= d_i;
        end else begin
          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdf_thermal.sv
module cdf_thermal
  import cdf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic shut_i,
  input  logic cool_i,
  output logic warn_act_o,
  output logic shut_act_o
);
  therm_e state_q, state_nx;

  always_comb begin
    state_nx = state_q;
    if (shut_i) begin
      state_nx = TH_SHUT;
    end else if (warn_i) begin
      if (state_q != TH_SHUT) state_nx = TH_WARN;
    end else if (cool_i) begin
      state_nx = TH_NORM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TH_NORM;
    else        state_q <= state_nx;
  end

  assign warn_act_o = (state_q != TH_NORM);
  assign shut_act_o = (state_q == TH_SHUT);

  AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TH_SHUT) && !cool_i |=> (state_q == TH_SHUT)); // R3
  AST_WARN_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    warn_i |=> (state_q != TH_NORM)); // R1
endmodule

// File: rtl/cdf_ocp.sv
module cdf_ocp #(
  parameter int NUM_FET = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FET-1:0] oc_i,
  input  logic               mute_n_i,
  output logic               oc_lat_o
);
  logic oc_lat_q, oc_lat_nx;
  logic mute_q;
  logic mute_rel;
  logic any_oc;

  assign any_oc   = |oc_i;
  assign mute_rel = mute_n_i & ~mute_q;

  always_comb begin
    oc_lat_nx = oc_lat_q;
    if (any_oc)        oc_lat_nx = 1'b1;
    else if (mute_rel) oc_lat_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lat_q <= 1'b0;
      mute_q   <= 1'b0;
    end else begin
      oc_lat_q <= oc_lat_nx;
      mute_q   <= mute_n_i;
    end
  end

  assign oc_lat_o = oc_lat_q;

  AST_OC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_oc |=> oc_lat_q); // R4
  AST_OC_CLEAR_ON_UNMUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oc_lat_q) |-> $past(mute_rel)); // R5
endmodule

// File: rtl/cdf_activity.sv
module cdf_activity #(
  parameter int DLOSS_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic sig_i,
  output logic timeout_o
);
  localparam int CW = $clog2(DLOSS_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(DLOSS_TICKS);

  logic          sig_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          edge_seen;

  assign edge_seen = sig_i ^ sig_q;

  always_comb begin
    cnt_nx = cnt_q;
    if (!en_i || edge_seen)             cnt_nx = '0;
    else if (tick_i && (cnt_q != LIM))  cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sig_q <= sig_i;
      cnt_q <= cnt_nx;
    end
  end

  assign timeout_o = (cnt_q == LIM);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !timeout_o); // R7
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !timeout_o); // R6
endmodule

// File: rtl/cdf_supervisor.sv
module cdf_supervisor
  import cdf_pkg::*;
#(
  parameter int NUM_PWM     = 4,
  parameter int NUM_FET     = 8,
  parameter int DLOSS_TICKS = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bridge_mode_i,
  input  logic               tick_i,
  input  logic [NUM_PWM-1:0] pwm_i,
  input  logic               mute_n_i,
  input  logic               tmp_warn_i,
  input  logic               tmp_shut_i,
  input  logic               tmp_cool_i,
  input  logic [NUM_FET-1:0] oc_i,
  output logic               out_en_o,
  output logic               warn_n_o,
  output logic               shut_n_o,
  output logic               oc_n_o,
  output logic               dloss_n_o
);
  localparam int SW = 4 + NUM_FET + NUM_PWM;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [SW-1:0]      sync_d, sync_q;
  logic               warn_s, shut_s, cool_s, mute_s;
  logic [NUM_FET-1:0] oc_s;
  logic [NUM_PWM-1:0] pwm_s;
  logic [NUM_PWM-1:0] tmo;
  logic               warn_act, shut_act, oc_lat;
  logic               out_en_q, out_en_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sync_d = {tmp_warn_i, tmp_shut_i, tmp_cool_i, mute_n_i, oc_i, pwm_i};

  cdf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  assign {warn_s, shut_s, cool_s, mute_s, oc_s, pwm_s} = sync_q;

  cdf_thermal u_thermal (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .warn_i     (warn_s),
    .shut_i     (shut_s),
    .cool_i     (cool_s),
    .warn_act_o (warn_act),
    .shut_act_o (shut_act)
  );

  cdf_ocp #(.NUM_FET(NUM_FET)) u_ocp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .oc_i     (oc_s),
    .mute_n_i (mute_s),
    .oc_lat_o (oc_lat)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_PWM; c++) begin : g_chan
      if ((c % 2) == 0) begin : g_mon
        cdf_activity #(.DLOSS_TICKS(DLOSS_TICKS)) u_act (
          .clk       (clk),
          .rst_n     (rst_int_n),
          .en_i      (bridge_mode_i),
          .tick_i    (tick_i),
          .sig_i     (pwm_s[c]),
          .timeout_o (tmo[c])
        );
      end else begin : g_unmon
        assign tmo[c] = 1'b0;
      end
    end
  endgenerate

  assign out_en_nx = mute_s & ~shut_act & ~oc_lat;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_en_q <= 1'b0;
    else            out_en_q <= out_en_nx;
  end

  assign out_en_o  = out_en_q;
  assign warn_n_o  = ~warn_act;
  assign shut_n_o  = ~shut_act;
  assign oc_n_o    = ~oc_lat;
  assign dloss_n_o = ~(|tmo);

  AST_SHUT_GATES: assert property (@(posedge clk) disable iff (!rst_int_n)
    shut_act |=> !out_en_q); // R2
  AST_OC_GATES: assert property (@(posedge clk) disable iff (!rst_int_n)
    oc_lat |=> !out_en_q); // R4
  AST_MUTE_GATES: assert property (@(posedge clk) disable iff (!rst_int_n)
    !mute_s |=> !out_en_q); // R8
endmodule

// File: tb/cdf_supervisor_tb.sv
module cdf_supervisor_tb;
  localparam int LIM = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bridge_mode;
  logic       tick;
  logic [3:0] pwm;
  logic       mute_n;
  logic       t_warn, t_shut, t_cool;
  logic [7:0] oc;
  logic       out_en, warn_n, shut_n, oc_n, dloss_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdf_supervisor #(.NUM_PWM(4), .NUM_FET(8), .DLOSS_TICKS(LIM)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bridge_mode_i (bridge_mode),
    .tick_i        (tick),
    .pwm_i         (pwm),
    .mute_n_i      (mute_n),
    .tmp_warn_i    (t_warn),
    .tmp_shut_i    (t_shut),
    .tmp_cool_i    (t_cool),
    .oc_i          (oc),
    .out_en_o      (out_en),
    .warn_n_o      (warn_n),
    .shut_n_o      (shut_n),
    .oc_n_o        (oc_n),
    .dloss_n_o     (dloss_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle(input int n = 6);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    settle(2);
    rst_n = 1'b1;
    settle(4);
  endtask

  initial begin
    rst_n = 1'b0; bridge_mode = 1'b1; tick = 1'b0; pwm = 4'h0;
    mute_n = 1'b1; t_warn = 1'b0; t_shut = 1'b0; t_cool = 1'b1; oc = 8'h00;
    settle(2);
    // R9: state during reset
    chk("R9 out_en in reset", out_en, 1'b0);
    chk("R9 oc_n in reset", oc_n, 1'b1);
    chk("R9 warn_n in reset", warn_n, 1'b1);
    rst_n = 1'b1;
    settle();
    chk("R8 out_en after release", out_en, 1'b1);

    // R1 warning alone
    t_cool = 1'b0; t_warn = 1'b1; settle();
    chk("R1 warn_n", warn_n, 1'b0);
    chk("R1 out_en kept", out_en, 1'b1);
    t_warn = 1'b0; settle();
    chk("R3 warn held without cool", warn_n, 1'b0);
    t_cool = 1'b1; settle();
    chk("R3 warn released on cool", warn_n, 1'b1);

    // R2/R3 shutdown walk
    t_cool = 1'b0; t_warn = 1'b1; t_shut = 1'b1; settle();
    chk("R2 shut_n", shut_n, 1'b0);
    chk("R2 warn_n", warn_n, 1'b0);
    chk("R2 out_en off", out_en, 1'b0);
    t_shut = 1'b0; settle();
    chk("R3 shut held below shut flag", shut_n, 1'b0);
    chk("R3 out_en still off", out_en, 1'b0);
    t_warn = 1'b0; settle();
    chk("R3 shut held above cool", shut_n, 1'b0);
    t_cool = 1'b1; settle();
    chk("R3 shut released", shut_n, 1'b1);
    chk("R3 warn released", warn_n, 1'b1);
    chk("R3 out_en back", out_en, 1'b1);

    // R4/R5 sweep over every transistor flag
    for (int k = 0; k < 8; k++) begin
      oc = 8'h01 << k; settle();
      chk($sformatf("R4 oc_n bit%0d", k), oc_n, 1'b0);
      chk($sformatf("R4 out_en bit%0d", k), out_en, 1'b0);
      mute_n = 1'b0; settle(); mute_n = 1'b1; settle();
      chk($sformatf("R5 unmute with flag bit%0d", k), oc_n, 1'b0);
      oc = 8'h00; settle();
      chk($sformatf("R4 latched bit%0d", k), oc_n, 1'b0);
      chk($sformatf("R4 out_en latched bit%0d", k), out_en, 1'b0);
      mute_n = 1'b0; settle();
      chk($sformatf("R8 muted bit%0d", k), out_en, 1'b0);
      chk($sformatf("R5 mute asserted only bit%0d", k), oc_n, 1'b0);
      mute_n = 1'b1; settle();
      chk($sformatf("R5 cleared bit%0d", k), oc_n, 1'b1);
      chk($sformatf("R5 out_en bit%0d", k), out_en, 1'b1);
    end

    // R5/R9 clear by reset
    oc = 8'h80; settle(); oc = 8'h00; settle();
    chk("R4 latched before reset", oc_n, 1'b0);
    rst_n = 1'b0; #1;
    chk("R9 oc_n immediate", oc_n, 1'b1);
    chk("R9 out_en immediate", out_en, 1'b0);
    settle(2); rst_n = 1'b1; settle();
    chk("R5 reset cleared", oc_n, 1'b1);

    // R6 bridged activity timeout on each monitored channel
    for (int ch = 0; ch < 4; ch += 2) begin
      pwm = 4'h0; do_reset();
      pwm[ch] = ~pwm[ch]; settle(4);
      for (int t = 0; t < LIM - 1; t++) begin
        pulse_tick(); pwm[2-ch] = ~pwm[2-ch]; settle(4);
      end
      chk($sformatf("R6 ch%0d below limit", ch), dloss_n, 1'b1);
      pulse_tick(); settle(1);
      chk($sformatf("R6 ch%0d at limit", ch), dloss_n, 1'b0);
      pwm[ch] = ~pwm[ch]; settle(4);
      chk($sformatf("R6 ch%0d edge restarts", ch), dloss_n, 1'b1);
    end

    // R6 unused channels: only 1 and 3 idle, 0 and 2 toggle
    pwm = 4'h0; do_reset();
    for (int t = 0; t < 3 * LIM; t++) begin
      pwm[0] = ~pwm[0]; pwm[2] = ~pwm[2]; settle(4); pulse_tick();
    end
    settle(1);
    chk("R6 channels 1,3 ignored", dloss_n, 1'b1);

    // R7 single-ended mode: no monitoring
    bridge_mode = 1'b0; pwm = 4'h0; do_reset();
    for (int t = 0; t < 3 * LIM; t++) pulse_tick();
    settle(1);
    chk("R7 no data loss in 4-channel", dloss_n, 1'b1);
    chk("R8 out_en in 4-channel", out_en, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule